// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a synthesizable I2C target that models a byte-wide serial EEPROM. With the array width set to 15 it holds 32 KB, organised as 512 pages of 64 bytes. The default build uses a smaller array so that elaboration stays light. The array width and the page width are both parameters. The block samples the bus lines with a two-flop synchroniser and finds START and STOP as SDA edges while SCL is high. It answers to a seven-bit device address: the fixed prefix 1010 followed by three strap inputs, so that up to eight of these devices can share one bus.

A write transfer sends the device address with the R/W bit at 0. Then it sends the memory address as a high byte and a low byte, then data bytes. During a multi-byte write the address steps only inside the current page. After the last byte of the page it wraps to the first byte of the same page and overwrites what is there. A random read is a write of the address with no data, then a repeated START, then the device address with the R/W bit at 1. Read data then streams out. The read address steps across the whole array and rolls over from the last byte to 0.

The block exists so that an I2C master can be checked against realistic page-wrap behaviour. Clock stretching, write-cycle busy time and acknowledge polling are not modelled.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, and at any time outside an acknowledge slot or a read bit, `sda_oe` is 0 (SDA released).
- R2: A first byte after START whose upper seven bits equal {1010, `strap`} is acknowledged by pulling SDA low for the ninth clock. Any other value gets no acknowledge, and SDA stays released until the next START. R/W is bit 0 of that byte, and 0 means write.
- R3: The memory address is taken as a high byte, then a low byte. Address bits at and above the array width are ignored (bit 15 at full size).
- R4: Each data byte of a write transfer is acknowledged and stored at the current address.
- R5: During a write, the offset (address bits 5..0) steps from 63 back to 0 of the same page. The page bits do not change, and earlier bytes of that page are overwritten.
- R6: While `wp` is 1, data bytes are still acknowledged, but the memory is left unchanged.
- R7: A random read (address write, repeated START, read address) returns the byte stored at that address, MSB first.
- R8: A sequential read steps the address by one across page boundaries and rolls over from the last byte of the array to address 0.
- R9: When the master does not acknowledge a read byte, the target releases SDA and drives nothing more until the next START.
- R10: A START at any point restarts device-address decoding. A STOP returns the target to idle. An address transfer cut short by STOP or START leaves the current address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain), 0 releases it |
| strap | input | 3 | Low three bits of the device address |
| wp | input | 1 | Write protect; 1 discards all write data |

## Verification
Assertions check on every cycle that:
- SDA is driven only in an acknowledge slot or a read bit;
- a STOP or a non-matching address leaves SDA released;
- a stored byte never moves the address to another page;
- each read byte advances the address by exactly one;
- a master NACK releases the line.

Only the bench's transfers can show that the right data reaches the right cell. That covers page-wrap overwrites, the write-protect discard, rollover at the array end, ignored high address bits, and a current address that survives an aborted address phase.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } eep_state_t;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_HI,
    PH_LO,
    PH_DATA
  } eep_phase_t;

endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [SYNC_N-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_N-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_N-2:0], sda_i};
      scl_d  <= scl_sh[SYNC_N-1];
      sda_d  <= sda_sh[SYNC_N-1];
    end
  end

  assign scl_s     = scl_sh[SYNC_N-1];
  assign sda_s     = sda_sh[SYNC_N-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // bus conditions: SDA edge while SCL stays high across both samples
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eep_pkg::*;
#(
  parameter int         ARRAY_AW   = 11,
  parameter int         PAGE_AW    = 6,
  parameter logic [3:0] DEV_PREFIX = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap,
  input  logic       wp
);
  localparam int BIT_W = 4;

  // address arithmetic
  function automatic logic [ARRAY_AW-1:0] page_step(input logic [ARRAY_AW-1:0] a);
    return {a[ARRAY_AW-1:PAGE_AW], a[PAGE_AW-1:0] + 1'b1};
  endfunction

  function automatic logic [ARRAY_AW-1:0] array_step(input logic [ARRAY_AW-1:0] a);
    return a + 1'b1;
  endfunction

  // bus sensing
  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  i2c_bus_sense #(.SYNC_N(2)) u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .bus_start(bus_start),
    .bus_stop (bus_stop)
  );

  // state
  eep_state_t          state;
  eep_phase_t          phase;
  logic [BIT_W-1:0]    bit_cnt;
  logic [7:0]          shreg;
  logic [7:0]          hi_q;
  logic [7:0]          tx_q;
  logic [ARRAY_AW-1:0] addr_q;
  logic                go_read;
  logic                more;

  // named internal events
  logic       byte_evt, dev_hit, wr_evt, mem_we, tx_load, rack_end;
  logic [7:0] mem_rd;

  assign byte_evt = (state == ST_RX) && scl_fall && (bit_cnt == BIT_W'(8));
  assign dev_hit  = (shreg[7:1] == {DEV_PREFIX, strap});
  assign wr_evt   = byte_evt && (phase == PH_DATA);
  assign mem_we   = wr_evt && !wp && !bus_start && !bus_stop;
  assign rack_end = (state == ST_RACK) && scl_fall;
  assign tx_load  = ((state == ST_ACK) && scl_fall && go_read) || (rack_end && more);

  eep_mem #(.AW(ARRAY_AW)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .addr (addr_q),
    .wdata(shreg),
    .rdata(mem_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      phase   <= PH_DEV;
      bit_cnt <= '0;
      shreg   <= '0;
      hi_q    <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      go_read <= 1'b0;
      more    <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (bus_start) begin
      state   <= ST_RX;
      phase   <= PH_DEV;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (bus_stop) begin
      state   <= ST_IDLE;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_RX: begin
          if (scl_rise && bit_cnt < BIT_W'(8)) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_evt) begin
            bit_cnt <= '0;
            unique case (phase)
              PH_DEV: begin
                if (dev_hit) begin
                  sda_oe  <= 1'b1;
                  state   <= ST_ACK;
                  go_read <= shreg[0];
                  phase   <= PH_HI;
                end else begin
                  state   <= ST_IDLE;
                end
              end
              PH_HI: begin
                hi_q   <= shreg;
                phase  <= PH_LO;
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end
              PH_LO: begin
                addr_q <= ARRAY_AW'({hi_q, shreg});
                phase  <= PH_DATA;
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end
              PH_DATA: begin
                addr_q <= page_step(addr_q);
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (go_read) begin
              tx_q    <= mem_rd;
              sda_oe  <= ~mem_rd[7];
              addr_q  <= array_step(addr_q);
              bit_cnt <= '0;
              state   <= ST_TX;
            end else begin
              sda_oe  <= 1'b0;
              state   <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == BIT_W'(7)) begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
            end else begin
              tx_q    <= {tx_q[6:0], 1'b0};
              sda_oe  <= ~tx_q[6];
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) more <= ~sda_s;
          if (rack_end) begin
            if (more) begin
              tx_q    <= mem_rd;
              sda_oe  <= ~mem_rd[7];
              addr_q  <= array_step(addr_q);
              bit_cnt <= '0;
              state   <= ST_TX;
            end else begin
              state   <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // assertions
  assert_drive_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state == ST_ACK || state == ST_TX));

  assert_foreign_addr_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_evt && phase == PH_DEV && !dev_hit && !bus_start && !bus_stop) |=> !sda_oe);

  assert_page_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !bus_start && !bus_stop) |=>
      addr_q[ARRAY_AW-1:PAGE_AW] == $past(addr_q[ARRAY_AW-1:PAGE_AW]));

  assert_offset_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !bus_start && !bus_stop) |=>
      addr_q[PAGE_AW-1:0] == PAGE_AW'($past(addr_q[PAGE_AW-1:0]) + 1'b1));

  assert_read_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !bus_start && !bus_stop) |=> addr_q == ARRAY_AW'($past(addr_q) + 1'b1));

  assert_nack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rack_end && !more && !bus_start && !bus_stop) |=> (!sda_oe && state == ST_IDLE));

  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (!sda_oe && state == ST_IDLE));

endmodule

// File: tb/sim_i2c_eeprom_target.sv
`timescale 1ns/1ps
module sim_i2c_eeprom_target;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int Q     = 4;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;  // 50 MHz

  i2c_eeprom_target #(.ARRAY_AW(AW), .PAGE_AW(6)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap(STRAP), .wp(wp)
  );

  int checks = 0, errors = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [DEPTH];

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_line;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = !b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(!give_ack);
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {4'b1010, STRAP, rd};
  endfunction

  task automatic write_seq(input int a16, input int n, input string req);
    bit ak;
    bus_start();
    send_byte(dev(1'b0), ak); chk(ak, "R2", ak, 1);
    send_byte(8'(a16 >> 8), ak); chk(ak, "R3", ak, 1);
    send_byte(8'(a16), ak); chk(ak, "R3", ak, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ak); chk(ak, req, ak, 1);
    end
    bus_stop();
  endtask

  task automatic read_seq(input int a16, input int n);
    bit ak;
    bus_start();
    send_byte(dev(1'b0), ak); chk(ak, "R7", ak, 1);
    send_byte(8'(a16 >> 8), ak);
    send_byte(8'(a16), ak);
    bus_start();
    send_byte(dev(1'b1), ak); chk(ak, "R7", ak, 1);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    bit ak;
    logic b;
    logic [7:0] v;
    tick(5);
    chk(sda_oe == 1'b0, "R1 reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(10);
    chk(sda_oe == 1'b0, "R1 idle", sda_oe, 0);

    // R2: sweep all strap values plus a wrong prefix
    for (int k = 0; k < 9; k++) begin
      logic [7:0] d;
      d = (k < 8) ? {4'b1010, 3'(k), 1'b0} : {4'b1011, STRAP, 1'b0};
      bus_start();
      send_byte(d, ak);
      chk(ak == (k == int'(STRAP)), "R2 addr", ak, k == int'(STRAP));
      if (!ak) begin
        send_byte(8'h00, ak);
        chk(!ak, "R2 silent", ak, 0);
      end
      bus_stop();
    end

    // R4: fill every page, then R8: read the whole array in one sweep
    for (int p = 0; p < DEPTH / 64; p++) begin
      for (int i = 0; i < 64; i++) begin
        wbuf[i] = pat(p * 64 + i);
        model[p * 64 + i] = wbuf[i];
      end
      write_seq(p * 64, 64, "R4");
    end
    read_seq(0, DEPTH);
    for (int a = 0; a < DEPTH; a++)
      chk(rbuf[a] == model[a], "R8 R4 sweep", rbuf[a], model[a]);

    // R8: rollover from the last byte to 0
    read_seq(DEPTH - 1, 3);
    chk(rbuf[0] == model[DEPTH - 1], "R8 last", rbuf[0], model[DEPTH - 1]);
    chk(rbuf[1] == model[0], "R8 roll", rbuf[1], model[0]);
    chk(rbuf[2] == model[1], "R8 roll+1", rbuf[2], model[1]);

    // R5: page wrap from offset 60 of page 1
    for (int i = 0; i < 8; i++) begin
      wbuf[i] = 8'hC0 + 8'(i);
      model[64 + (60 + i) % 64] = wbuf[i];
    end
    write_seq(64 + 60, 8, "R5");
    read_seq(64, 128);
    for (int i = 0; i < 128; i++)
      chk(rbuf[i] == model[64 + i], "R5 wrap", rbuf[i], model[64 + i]);

    // R3: high address bits ignored
    wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
    model[8'h90] = 8'h5A; model[8'h91] = 8'hA5;
    write_seq(16'hA790, 2, "R3");
    read_seq(16'h0090, 2);
    chk(rbuf[0] == 8'h5A && rbuf[1] == 8'hA5, "R3 low", rbuf[0], 8'h5A);
    read_seq(16'hFF90, 2);
    chk(rbuf[0] == 8'h5A && rbuf[1] == 8'hA5, "R3 high", rbuf[0], 8'h5A);

    // R6: write protect discards data but still acknowledges
    wp = 1'b1;
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hEE;
    write_seq(16'h0030, 4, "R6 ack");
    wp = 1'b0;
    read_seq(16'h0030, 4);
    for (int i = 0; i < 4; i++)
      chk(rbuf[i] == model[8'h30 + i], "R6 kept", rbuf[i], model[8'h30 + i]);

    // R7: single random reads at scattered addresses
    for (int a = 3; a < DEPTH; a += 61) begin
      read_seq(a, 1);
      chk(rbuf[0] == model[a], "R7 random", rbuf[0], model[a]);
    end

    // R9: after master NACK the line stays released
    bus_start();
    send_byte(dev(1'b0), ak); send_byte(8'h00, ak); send_byte(8'h10, ak);
    bus_start();
    send_byte(dev(1'b1), ak);
    recv_byte(v, 1'b0);
    chk(v == model[8'h10], "R9 data", v, model[8'h10]);
    for (int i = 0; i < 9; i++) begin
      get_bit(b);
      chk(b == 1'b1, "R9 released", b, 1);
    end
    bus_stop();

    // R10: repeated START mid address restarts decoding
    bus_start();
    send_byte(dev(1'b0), ak); send_byte(8'h00, ak);
    bus_start();
    send_byte(dev(1'b0), ak); chk(ak, "R10 restart", ak, 1);
    send_byte(8'h00, ak); send_byte(8'h20, ak);
    send_byte(8'h3C, ak); chk(ak, "R10 data", ak, 1);
    bus_stop();
    model[8'h20] = 8'h3C;
    read_seq(16'h0020, 1);
    chk(rbuf[0] == 8'h3C, "R10 stored", rbuf[0], 8'h3C);
    // address phase cut by STOP leaves the pointer at 0x21
    bus_start();
    send_byte(dev(1'b0), ak); send_byte(8'h00, ak);
    bus_stop();
    bus_start();
    send_byte(dev(1'b1), ak); chk(ak, "R10 cur ack", ak, 1);
    recv_byte(v, 1'b0);
    bus_stop();
    chk(v == model[8'h21], "R10 pointer", v, model[8'h21]);
    chk(sda_oe == 1'b0, "R1 end", sda_oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule